// File: doc/BRIEF.md
# Busy Status Read Responder

This block sits on the read path of a word-wide non-volatile array with an internal write controller. While the controller reports that a write period is running, each read returns a status word instead of array contents. The status word is built from the last word the host loaded. In each byte lane, one bit is that word's bit inverted, and a second bit flips on every read. A host can use either indicator to tell when the write period has ended: it compares the inverted bit with the value it wrote, or it watches for the flipping bit to settle.

When the controller is idle, a read returns the array data presented at the input. The block makes no distinction between a real write and a write attempt that protection rejected. Both raise the same busy flag, so both make reads behave as polling for the whole period. A read is one clock-wide strobe. The word it selects appears on the output one clock later and stays there until the next strobe.

Top module: `busy_status_responder`

## Requirements
- R1: After reset, `rd_data_o` reads 0x0000 and the internal flip bit is 0, so the first read made while busy returns 0 in bits 6 and 14.
- R2: A read strobe taken while `busy_i` is high returns, one clock later, bits 7 and 15 equal to the complement of bits 7 and 15 of `last_word_i`.
- R3: Bits 6 and 14 of a busy read always carry the same value, and that value alternates on each successive busy read.
- R4: In a busy read, every bit other than 6, 7, 14 and 15 equals the matching bit of `last_word_i`.
- R5: A read strobe taken while `busy_i` is low returns `arr_data_i` unchanged one clock later, with no status bits inserted.
- R6: The flip bit advances only on a read strobe taken while busy. Clocks without a strobe and reads taken while idle leave it unchanged, so the next busy read continues the alternation.
- R7: `rd_data_o` changes only in the clock after a read strobe and holds its value otherwise.
- R8: Polling can start on the first clock that `busy_i` is high, and the first read after `busy_i` falls returns array data.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| busy_i | input | 1 | Write controller reports that a write period is running |
| last_word_i | input | 16 | Last word the host loaded |
| rd_stb_i | input | 1 | One-clock read strobe |
| arr_data_i | input | 16 | Array read data |
| rd_data_o | output | 16 | Read data, updated one clock after a strobe |

## Verification
The bench covers every single-bit pattern of the loaded word, plus the all-zero, all-one and checkerboard words. A design that inverted the wrong bit, or passed a status bit through uninverted, would produce a mismatch on one of those patterns. Busy reads are interleaved with idle reads and with gaps that have no strobe. A flip bit that advanced on every clock, or on idle reads, would then break the expected alternation. A design that let the two lanes' flip bits differ would also be caught. The transition cases are checked as well: a read on the first busy clock, and a read on the first idle clock after busy falls. A mux that lagged by a clock, or kept inserting status bits after busy fell, would return the wrong word in those cases.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic {
    SRC_ARRAY  = 1'b0,
    SRC_STATUS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bsr_toggle.sv
module bsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic tog_o
);
  logic tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (adv_i) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tog_o = tog_q;

  p_flip_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (tog_o != $past(tog_o)));
  p_hold_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(tog_o));
endmodule

// File: rtl/bsr_status_build.sv
module bsr_status_build #(
  parameter int DATA_W   = 16,
  parameter int LANE_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int FLIP_BIT = 6
) (
  input  logic [DATA_W-1:0] last_i,
  input  logic              tog_i,
  output logic [DATA_W-1:0] status_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane;
    always_comb begin
      lane           = last_i[l*LANE_W +: LANE_W];
      lane[POLL_BIT] = ~lane[POLL_BIT];
      lane[FLIP_BIT] = tog_i;
    end
    assign status_o[l*LANE_W +: LANE_W] = lane;
  end
endmodule

// File: rtl/busy_status_responder.sv
module busy_status_responder #(
  parameter int DATA_W   = 16,
  parameter int LANE_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int FLIP_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [15:0]       last_word_i,
  input  logic              rd_stb_i,
  input  logic [15:0]       arr_data_i,
  output logic [15:0]       rd_data_o
);
  import bsr_pkg::*;

  localparam int HI_POLL = LANE_W + POLL_BIT;
  localparam int HI_FLIP = LANE_W + FLIP_BIT;

  logic              rst_i_n;
  logic              tog;
  logic              adv;
  rd_src_e           src;
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_d, rd_q;

  bsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign adv = rd_stb_i & busy_i;

  bsr_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_i_n),
    .adv_i (adv),
    .tog_o (tog)
  );

  bsr_status_build #(
    .DATA_W   (DATA_W),
    .LANE_W   (LANE_W),
    .POLL_BIT (POLL_BIT),
    .FLIP_BIT (FLIP_BIT)
  ) u_build (
    .last_i   (last_word_i),
    .tog_i    (tog),
    .status_o (status_w)
  );

  always_comb begin
    src  = busy_i ? SRC_STATUS : SRC_ARRAY;
    rd_d = rd_q;
    if (rd_stb_i) rd_d = (src == SRC_STATUS) ? status_w : arr_data_i;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rd_q <= '0;
    else          rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  p_poll_inv_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_stb_i && busy_i) |=>
      (rd_data_o[POLL_BIT] == !$past(last_word_i[POLL_BIT])) &&
      (rd_data_o[HI_POLL]  == !$past(last_word_i[HI_POLL])));
  p_lanes_match_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_stb_i && busy_i) |=> (rd_data_o[FLIP_BIT] == rd_data_o[HI_FLIP]));
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_stb_i && busy_i) |=> (rd_data_o[FLIP_BIT] != tog));
  p_idle_data_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_stb_i && !busy_i) |=> (rd_data_o == $past(arr_data_i)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_stb_i |=> $stable(rd_data_o));
endmodule

// File: tb/tb_busy_status_responder.sv
module tb_busy_status_responder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        busy_i;
  logic [15:0] last_word_i;
  logic        rd_stb_i;
  logic [15:0] arr_data_i;
  logic [15:0] rd_data_o;

  int vectors = 0;
  int misses  = 0;
  logic tog_m;
  logic [15:0] prev;

  always #4 clk = ~clk;

  busy_status_responder dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .last_word_i (last_word_i),
    .rd_stb_i    (rd_stb_i),
    .arr_data_i  (arr_data_i),
    .rd_data_o   (rd_data_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] status_of(input logic [15:0] w, input logic t);
    logic [15:0] s;
    s = w ^ 16'h8080;
    s[6]  = t;
    s[14] = t;
    return s;
  endfunction

  // drive at negedge, strobe for one clock, sample at following negedge
  task automatic do_read(input logic b, input logic [15:0] lw, input logic [15:0] ad,
                         output logic [15:0] got);
    busy_i = b; last_word_i = lw; arr_data_i = ad; rd_stb_i = 1'b1;
    @(negedge clk);
    rd_stb_i = 1'b0;
    got = rd_data_o;
  endtask

  task automatic busy_read(input string req, input logic [15:0] lw);
    logic [15:0] g;
    do_read(1'b1, lw, ~lw, g);
    check(req, g, status_of(lw, tog_m));
    tog_m = ~tog_m;
  endtask

  task automatic idle_read(input string req, input logic [15:0] ad);
    logic [15:0] g;
    do_read(1'b0, 16'h1234, ad, g);
    check(req, g, ad);
  endtask

  initial begin
    #(8 * 150000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0; busy_i = 1'b0; last_word_i = '0; rd_stb_i = 1'b0; arr_data_i = '0;
    tog_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset data", rd_data_o, 16'h0000);
    // R1: first busy read shows flip bit 0; R8 first busy clock
    busy_read("R1 R8 first busy read", 16'h0000);
    // R2 R4: every single-bit word, plus corners
    for (int i = 0; i < 16; i++) busy_read("R2 R4 walking one", 16'h0001 << i);
    for (int i = 0; i < 16; i++) busy_read("R2 R4 walking zero", ~(16'h0001 << i));
    busy_read("R2 R4 all ones", 16'hFFFF);
    busy_read("R2 R4 checker", 16'hA5A5);
    busy_read("R2 R4 checker", 16'h5A5A);
    // R3: lane bits equal and alternating across back-to-back reads
    for (int i = 0; i < 8; i++) begin
      logic [15:0] g;
      do_read(1'b1, 16'h3C3C, 16'h0, g);
      check("R3 lanes equal", {15'd0, g[6]}, {15'd0, g[14]});
      check("R3 alternation", {15'd0, g[6]}, {15'd0, tog_m});
      tog_m = ~tog_m;
    end
    // R7 and R6: idle clocks with no strobe, output held, flip held
    prev = rd_data_o;
    busy_i = 1'b1; last_word_i = 16'hBEEF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R7 hold without strobe", rd_data_o, prev);
    end
    busy_read("R6 no advance without strobe", 16'hBEEF);
    // R5 R8: first read after busy falls, then an idle sweep
    idle_read("R8 first idle read", 16'hCAFE);
    for (int i = 0; i < 64; i++) idle_read("R5 idle array data", 16'(i * 1031 + 7));
    // R6: idle reads did not advance flip bit
    busy_read("R6 idle reads ignored", 16'h0F0F);
    busy_read("R6 continue alternation", 16'hF0F0);
    for (int i = 0; i < 16; i++) begin
      idle_read("R5 interleaved idle", 16'hFFFF >> i);
      busy_read("R3 interleaved busy", 16'h8001 << (i % 8));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule